// File: doc/BRIEF.md
# Two-Stage Divide-by-Sixty Event Counter

This block counts single-cycle enable pulses, one per input event, and divides their rate by sixty. It is made of two synchronous stages that share one system clock. The low stage is a BCD decade counter. The high stage counts modulo six and advances only when the decade stage rolls over. Fed with a 60 Hz event stream, the block produces one output cycle per second.

Both digits are visible at the ports: the BCD units digit and the 3-bit tens digit. A combinational terminal-count flag marks the enabled event on which the whole counter wraps from 59 to 0. The divided output is the top bit of the tens digit, so it is high through counts 40 to 59 of each cycle. A synchronous clear sets both stages to zero.

Top module: `div60_counter`

## Requirements
- R1: After reset (rst_n low at a clock edge), units, tens, tc and div_out are all 0.
- R2: On each clock edge with en high and clr low, units advances by one from 0 up to 9, and returns from 9 to 0. When en is low, units holds its value.
- R3: tens advances by one only on an edge where en is high and units is 9, and returns from 5 to 0. On every other edge without clr it holds its value.
- R4: tc is 1 in exactly those cycles where en is high and the count (tens*10 + units) is 59. It is combinational, so it is seen in the same cycle as en.
- R5: div_out equals bit 2 of tens, so it is 1 for counts 40 to 59. Its rising edges are spaced exactly 60 enabled events apart.
- R6: When clr is high at a clock edge, units and tens both become 0, whatever the level of en.
- R7: units never shows a value above 9 and tens never shows a value above 5. On any enabled step, a stage holding an unused code goes to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear; takes priority over en |
| en | input | 1 | One-cycle pulse per input event |
| units | output | 4 | BCD units digit |
| tens | output | 3 | Modulo-6 tens digit |
| tc | output | 1 | Terminal count: en high while the count is 59 |
| div_out | output | 1 | Divided output, one cycle per 60 events |

## Verification
The bench builds the block with its default moduli of ten and six. This makes the full 60-state cycle reachable within a few hundred cycles, so the run covers several complete wraps, including the 9-to-0 carry into tens and the 59-to-0 rollover. Runs of idle cycles, clear asserted alone and clear asserted together with en at count 59 check the hold and priority rules. The spacing between rising edges of div_out is measured against the 60-event period.

// File: rtl/div60_counter.sv
module div60_counter #(
  parameter int LO_MOD = 10,
  parameter int HI_MOD = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      en,
  output logic [$clog2(LO_MOD)-1:0] units,
  output logic [$clog2(HI_MOD)-1:0] tens,
  output logic                      tc,
  output logic                      div_out
);
  localparam int LO_W = $clog2(LO_MOD);
  localparam int HI_W = $clog2(HI_MOD);
  localparam logic [LO_W-1:0] LO_TOP = LO_W'(LO_MOD - 1);
  localparam logic [HI_W-1:0] HI_TOP = HI_W'(HI_MOD - 1);

  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;

  wire lo_last = (lo_q == LO_TOP);
  wire hi_last = (hi_q == HI_TOP);
  wire lo_bad  = (lo_q > LO_TOP);
  wire hi_bad  = (hi_q > HI_TOP);
  wire carry   = en & lo_last;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      lo_q <= '0;
    else if (en)
      lo_q <= (lo_last || lo_bad) ? '0 : lo_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      hi_q <= '0;
    else if (en && hi_bad)
      hi_q <= '0;
    else if (carry)
      hi_q <= hi_last ? '0 : hi_q + 1'b1;
  end

  assign units   = lo_q;
  assign tens    = hi_q;
  assign tc      = carry & hi_last;
  assign div_out = hi_q[HI_W-1];
endmodule

module div60_counter_chk #(
  parameter int LO_MOD = 10,
  parameter int HI_MOD = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      clr,
  input logic                      en,
  input logic [$clog2(LO_MOD)-1:0] units,
  input logic [$clog2(HI_MOD)-1:0] tens,
  input logic                      tc,
  input logic                      div_out
);
  localparam int LO_W = $clog2(LO_MOD);
  localparam int HI_W = $clog2(HI_MOD);

  a_r2_units_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(en) && !$past(clr) && $past(units) != LO_W'(LO_MOD-1))
      |-> units == $past(units) + 1'b1);

  a_r2_units_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(en) && !$past(clr)) |-> $stable(units));

  a_r3_tens_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(clr) && !($past(en) && $past(units) == LO_W'(LO_MOD-1)))
      |-> $stable(tens));

  a_r4_tc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> (units == '0 && tens == '0));

  a_r5_div_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(div_out)) |-> (tens == HI_W'(1 << (HI_W-1)) && units == '0));

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(clr)) |-> (units == '0 && tens == '0));

  a_r7_legal: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (units <= LO_W'(LO_MOD-1) && tens <= HI_W'(HI_MOD-1)));
endmodule

bind div60_counter div60_counter_chk #(.LO_MOD(LO_MOD), .HI_MOD(HI_MOD)) u_chk (.*);

// File: tb/div60_counter_test.sv
module div60_counter_test;
  logic clk = 0, rst_n = 0, clr = 0, en = 0;
  logic [3:0] units;
  logic [2:0] tens;
  logic tc, div_out;
  int checks = 0, failures = 0;
  int cnt = 0;
  int ev = 0, last_rise = -1;
  logic prev_div = 0;
  bit done = 0;

  always #10 clk = ~clk;

  div60_counter uut (.clk(clk), .rst_n(rst_n), .clr(clr), .en(en),
    .units(units), .tens(tens), .tc(tc), .div_out(div_out));

  // {clr, en, repeat count}
  localparam logic [9:0] VEC [10] = '{
    {1'b0, 1'b1, 8'd9},   {1'b0, 1'b0, 8'd5},  {1'b0, 1'b1, 8'd1},
    {1'b0, 1'b1, 8'd49},  {1'b0, 1'b1, 8'd1},  {1'b0, 1'b1, 8'd23},
    {1'b1, 1'b1, 8'd1},   {1'b0, 1'b1, 8'd37}, {1'b1, 1'b0, 8'd1},
    {1'b0, 1'b1, 8'd200}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit c, input bit e);
    @(negedge clk);
    clr = c; en = e;
    #2;
    check(tc == (e && cnt == 59), "R4 tc", int'(tc), int'(e && cnt == 59));
    @(posedge clk);
    #2;
    if (c) cnt = 0;
    else if (e) begin cnt = (cnt + 1) % 60; ev++; end
    if (c) ev = 0;
    check(int'(units) == cnt % 10, c ? "R6 units clear" : "R2 units", int'(units), cnt % 10);
    check(int'(tens) == cnt / 10, c ? "R6 tens clear" : "R3 tens", int'(tens), cnt / 10);
    check(units <= 9 && tens <= 5, "R7 legal", int'(units) + 16*int'(tens), cnt % 10 + 16*(cnt / 10));
    check(div_out == (cnt >= 40), "R5 div_out level", int'(div_out), int'(cnt >= 40));
    if (div_out && !prev_div) begin
      if (last_rise >= 0) check(ev - last_rise == 60, "R5 div period", ev - last_rise, 60);
      last_rise = ev;
    end
    if (c) last_rise = -1;
    prev_div = div_out;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(units == 0 && tens == 0 && tc == 0 && div_out == 0, "R1 reset",
          int'(units) + int'(tens) + int'(tc) + int'(div_out), 0);
    @(negedge clk); rst_n = 1;
    foreach (VEC[i]) begin
      for (int k = 0; k < int'(VEC[i][7:0]); k++) step(VEC[i][9], VEC[i][8]);
    end
    // R6: clear and enable together at count 59
    while (cnt != 59) step(0, 1);
    step(1, 1);
    // R4: idle at 59 gives no tc
    step(1, 0);
    for (int k = 0; k < 59; k++) step(0, 1);
    step(0, 0);
    step(0, 1);
    // R1: reset mid-count
    repeat (7) step(0, 1);
    @(negedge clk); rst_n = 0; en = 1;
    @(posedge clk); #2;
    check(units == 0 && tens == 0, "R1 reset mid-count", int'(units) + 16*int'(tens), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule